// File: doc/BRIEF.md
# Serial Data Buffer Interrupt Flags

This block holds the status and request flags that sit beside a double-buffered serial data register in an I2C-style controller. Two data flags follow the buffers: one says the transmit buffer is empty and may be refilled, the other says the receive buffer holds a byte that has not been taken yet. On top of these sit a CPU interrupt flag and a separate DMA transfer-request flag. The bit engine feeds the block single-cycle event strobes: start seen, stop seen, eighth clock of a byte, transmit buffer moved to the shift register, shift register moved to the receive buffer, own or general-call address matched. Level inputs give the direction and the frame format.

The CPU clears the interrupt flag with a write of 0 to its control bit, but only after it has read that bit as 1. A DMA access to the data register clears the interrupt and request flags automatically, so a run of bytes needs no CPU help, except on the final access of a programmed count: there the data flag clears and the interrupt and request flags stay up for the CPU. While a slave transfer is still in its addressing phase, data events raise the interrupt but never the DMA request. All flags update on the clock edge that samples their cause. A synchronous active-high reset clears every flag.

Top module: `sbuf_irq_flags`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `irq_flag`, `dreq_flag`, `tx_empty`, `rx_full` and the internal read-as-1 latch on that edge.
- R2: With `fmt_sync`=1 (clocked-synchronous format), `ev_byte_end` or `ev_start` sets `irq_flag` at the next edge in either direction, without touching the data flags or `dreq_flag`.
- R3: With `mode_tx`=1 (transmit), `ev_start` sets `irq_flag` and `tx_empty`, and sets `dreq_flag` unless the slave addressing hold is active.
- R4: With `mode_tx`=1, `ev_tx_load` sets `tx_empty` and `irq_flag` (and `dreq_flag` unless held); with `mode_tx`=0 it has no effect on any flag.
- R5: With `mode_tx`=0 (receive), `ev_rx_store` sets `rx_full` and `irq_flag` (and `dreq_flag` unless held).
- R6: A CPU control write (`cpu_wr_ctrl`) with `cpu_wdata_irq`=0 clears `irq_flag` only if a control read (`cpu_rd_ctrl`) saw `irq_flag`=1 after the previous control write; every control write consumes that latch; a write with `cpu_wdata_irq`=1 never changes `irq_flag`, and a CPU clear leaves `dreq_flag` alone.
- R7: When a set event and a clear of `irq_flag` fall in the same cycle, the set wins and `irq_flag` stays 1.
- R8: A DMA data access with `dma_last`=0 clears `irq_flag` and `dreq_flag`; `dma_rd_data` clears `rx_full` and `dma_wr_data` clears `tx_empty`.
- R9: A DMA data access with `dma_last`=1 clears its data flag as in R8 but leaves `irq_flag` and `dreq_flag` unchanged.
- R10: In I2C format (`fmt_sync`=0) with `slave_sel`=1, `ev_addr_match` starts a hold (including its own cycle) during which data events set their flags and `irq_flag` but not `dreq_flag`; `ev_start` or `ev_stop` ends the hold.
- R11: A CPU data read (`cpu_rd_data`) clears `rx_full`, a CPU data write (`cpu_wr_data`) clears `tx_empty`, and either one clears `dreq_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_tx | input | 1 | 1 transmit, 0 receive |
| fmt_sync | input | 1 | 1 clocked-synchronous format, 0 I2C format |
| slave_sel | input | 1 | Controller acts as I2C slave |
| ev_start | input | 1 | Start or repeated start detected |
| ev_stop | input | 1 | Stop detected |
| ev_byte_end | input | 1 | Rising edge of the eighth transfer clock |
| ev_tx_load | input | 1 | Transmit buffer moved to shift register |
| ev_rx_store | input | 1 | Shift register moved to receive buffer |
| ev_addr_match | input | 1 | Own address or general-call address matched |
| cpu_rd_ctrl | input | 1 | CPU reads the control bit holding the interrupt flag |
| cpu_wr_ctrl | input | 1 | CPU writes that control bit |
| cpu_wdata_irq | input | 1 | Value written to the interrupt flag bit |
| cpu_rd_data | input | 1 | CPU reads the data register |
| cpu_wr_data | input | 1 | CPU writes the data register |
| dma_rd_data | input | 1 | DMA reads the data register |
| dma_wr_data | input | 1 | DMA writes the data register |
| dma_last | input | 1 | This DMA access is the last of the programmed count |
| irq_flag | output | 1 | CPU interrupt flag |
| dreq_flag | output | 1 | DMA transfer-request flag |
| tx_empty | output | 1 | Transmit buffer empty |
| rx_full | output | 1 | Receive buffer full |

## Verification
The assertions watch on every cycle that reset empties all flags, that each data event in the right direction raises its data flag and the interrupt, that the interrupt flag never drops without a control write or a DMA access, that a write of 1 or a last DMA access leaves it up, and that a DMA read empties the receive flag. The read-before-clear sequence, the consumption of the latch by every control write, set-over-clear priority and the addressing hold that keeps the DMA request down until a start or stop all depend on history, so only the bench's ordered scenarios show them.

// File: rtl/sbuf_flags_pkg.sv
package sbuf_flags_pkg;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    typedef enum logic {
        FMT_I2C  = 1'b0,
        FMT_SYNC = 1'b1
    } fmt_e;

    // Set requests produced by the event decoder for one cycle.
    typedef struct packed {
        logic irq;
        logic empty;
        logic full;
    } set_req_t;

    // One cycle of DMA data-register access.
    typedef struct packed {
        logic rd;
        logic wr;
        logic last;
    } dma_acc_t;

    function automatic logic dma_any(dma_acc_t d);
        return d.rd | d.wr;
    endfunction

    function automatic logic dma_mid(dma_acc_t d);
        return (d.rd | d.wr) & ~d.last;
    endfunction

endpackage

// File: rtl/sbuf_set_decode.sv
module sbuf_set_decode
    import sbuf_flags_pkg::*;
(
    input  dir_e     dir,
    input  fmt_e     fmt,
    input  logic     ev_start,
    input  logic     ev_byte_end,
    input  logic     ev_tx_load,
    input  logic     ev_rx_store,
    output set_req_t set_req
);

    always_comb begin
        set_req = '0;
        // Clocked-synchronous format: byte end and start raise the interrupt.
        if (fmt == FMT_SYNC && (ev_byte_end || ev_start)) begin
            set_req.irq = 1'b1;
        end
        // Transmit direction: start or buffer-to-shift move empties the buffer.
        if (dir == DIR_TX && (ev_start || ev_tx_load)) begin
            set_req.irq   = 1'b1;
            set_req.empty = 1'b1;
        end
        // Receive direction: shift-to-buffer move fills the buffer.
        if (dir == DIR_RX && ev_rx_store) begin
            set_req.irq  = 1'b1;
            set_req.full = 1'b1;
        end
    end

endmodule

// File: rtl/sbuf_addr_hold.sv
module sbuf_addr_hold
    import sbuf_flags_pkg::*;
#(
    parameter bit HOLD_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  fmt_e fmt,
    input  logic slave_sel,
    input  logic ev_start,
    input  logic ev_stop,
    input  logic ev_addr_match,
    output logic hold_now
);

    generate
        if (HOLD_EN) begin : g_hold
            logic hold_q;
            logic hold_d;

            always_comb begin
                hold_d = hold_q;
                if (ev_start || ev_stop) begin
                    hold_d = 1'b0;
                end
                if (ev_addr_match && slave_sel && fmt == FMT_I2C) begin
                    hold_d = 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_q <= 1'b0;
                end else begin
                    hold_q <= hold_d;
                end
            end

            // The matching cycle itself is already inside the hold.
            assign hold_now = hold_d;
        end else begin : g_no_hold
            assign hold_now = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/sbuf_irq_flag.sv
module sbuf_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_irq,
    input  logic cpu_rd,
    input  logic cpu_wr,
    input  logic cpu_wdata,
    input  logic dma_clr,
    output logic irq
);

    logic irq_q;
    logic irq_d;
    logic armed_q;
    logic armed_d;

    always_comb begin
        irq_d   = irq_q;
        armed_d = armed_q;
        if (cpu_rd && irq_q) begin
            armed_d = 1'b1;
        end
        if (cpu_wr) begin
            armed_d = 1'b0;
            if (!cpu_wdata && armed_q) begin
                irq_d = 1'b0;
            end
        end
        if (dma_clr) begin
            irq_d = 1'b0;
        end
        if (set_irq) begin
            irq_d = 1'b1;
        end
        if (!irq_d) begin
            armed_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            irq_q   <= irq_d;
            armed_q <= armed_d;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/sbuf_data_flags.sv
module sbuf_data_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_empty,
    input  logic set_full,
    input  logic hold,
    input  logic clr_empty,
    input  logic clr_full,
    input  logic clr_dreq,
    output logic empty,
    output logic full,
    output logic dreq
);

    logic set_dreq;

    assign set_dreq = (set_empty | set_full) & ~hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            empty <= 1'b0;
            full  <= 1'b0;
            dreq  <= 1'b0;
        end else begin
            if (set_empty) begin
                empty <= 1'b1;
            end else if (clr_empty) begin
                empty <= 1'b0;
            end
            if (set_full) begin
                full <= 1'b1;
            end else if (clr_full) begin
                full <= 1'b0;
            end
            if (set_dreq) begin
                dreq <= 1'b1;
            end else if (clr_dreq) begin
                dreq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sbuf_irq_flags.sv
module sbuf_irq_flags
    import sbuf_flags_pkg::*;
#(
    parameter bit HOLD_EN      = 1'b1,
    parameter bit DMA_AUTO_CLR = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_tx,
    input  logic fmt_sync,
    input  logic slave_sel,
    input  logic ev_start,
    input  logic ev_stop,
    input  logic ev_byte_end,
    input  logic ev_tx_load,
    input  logic ev_rx_store,
    input  logic ev_addr_match,
    input  logic cpu_rd_ctrl,
    input  logic cpu_wr_ctrl,
    input  logic cpu_wdata_irq,
    input  logic cpu_rd_data,
    input  logic cpu_wr_data,
    input  logic dma_rd_data,
    input  logic dma_wr_data,
    input  logic dma_last,
    output logic irq_flag,
    output logic dreq_flag,
    output logic tx_empty,
    output logic rx_full
);

    dir_e     dir;
    fmt_e     fmt;
    set_req_t set_req;
    dma_acc_t dma;
    logic     hold;
    logic     dma_irq_clr;
    logic     dreq_clr;

    assign dir = dir_e'(mode_tx);
    assign fmt = fmt_e'(fmt_sync);
    assign dma = '{rd: dma_rd_data, wr: dma_wr_data, last: dma_last};

    generate
        if (DMA_AUTO_CLR) begin : g_dma_clr
            assign dma_irq_clr = dma_mid(dma);
            assign dreq_clr    = dma_mid(dma) | cpu_rd_data | cpu_wr_data;
        end else begin : g_cpu_clr
            assign dma_irq_clr = 1'b0;
            assign dreq_clr    = (dma_any(dma) & ~dma.last) | cpu_rd_data | cpu_wr_data;
        end
    endgenerate

    sbuf_set_decode u_decode (
        .dir         (dir),
        .fmt         (fmt),
        .ev_start    (ev_start),
        .ev_byte_end (ev_byte_end),
        .ev_tx_load  (ev_tx_load),
        .ev_rx_store (ev_rx_store),
        .set_req     (set_req)
    );

    sbuf_addr_hold #(
        .HOLD_EN (HOLD_EN)
    ) u_hold (
        .clk           (clk),
        .rst           (rst),
        .fmt           (fmt),
        .slave_sel     (slave_sel),
        .ev_start      (ev_start),
        .ev_stop       (ev_stop),
        .ev_addr_match (ev_addr_match),
        .hold_now      (hold)
    );

    sbuf_irq_flag u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_irq   (set_req.irq),
        .cpu_rd    (cpu_rd_ctrl),
        .cpu_wr    (cpu_wr_ctrl),
        .cpu_wdata (cpu_wdata_irq),
        .dma_clr   (dma_irq_clr),
        .irq       (irq_flag)
    );

    sbuf_data_flags u_data (
        .clk       (clk),
        .rst       (rst),
        .set_empty (set_req.empty),
        .set_full  (set_req.full),
        .hold      (hold),
        .clr_empty (cpu_wr_data | dma.wr),
        .clr_full  (cpu_rd_data | dma.rd),
        .clr_dreq  (dreq_clr),
        .empty     (tx_empty),
        .full      (rx_full),
        .dreq      (dreq_flag)
    );

endmodule

// File: rtl/sbuf_irq_flags_chk.sv
module sbuf_irq_flags_chk (
    input logic clk,
    input logic rst,
    input logic mode_tx,
    input logic fmt_sync,
    input logic ev_start,
    input logic ev_byte_end,
    input logic ev_tx_load,
    input logic ev_rx_store,
    input logic cpu_wr_ctrl,
    input logic cpu_wdata_irq,
    input logic cpu_rd_data,
    input logic cpu_wr_data,
    input logic dma_rd_data,
    input logic dma_wr_data,
    input logic dma_last,
    input logic irq_flag,
    input logic dreq_flag,
    input logic tx_empty,
    input logic rx_full
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!irq_flag && !dreq_flag && !tx_empty && !rx_full));

    a_r2_sync_sets_irq: assert property (@(posedge clk) disable iff (rst)
        (fmt_sync && (ev_byte_end || ev_start)) |=> irq_flag);

    a_r4_tx_load_sets: assert property (@(posedge clk) disable iff (rst)
        (mode_tx && ev_tx_load) |=> (irq_flag && tx_empty));

    a_r5_rx_store_sets: assert property (@(posedge clk) disable iff (rst)
        (!mode_tx && ev_rx_store) |=> (irq_flag && rx_full));

    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !cpu_wr_ctrl && !dma_rd_data && !dma_wr_data) |=> irq_flag);

    a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && cpu_wr_ctrl && cpu_wdata_irq && !dma_rd_data && !dma_wr_data)
        |=> irq_flag);

    a_r8_dma_read_empties: assert property (@(posedge clk) disable iff (rst)
        (dma_rd_data && !(!mode_tx && ev_rx_store)) |=> !rx_full);

    a_r9_last_keeps: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && dreq_flag && (dma_rd_data || dma_wr_data) && dma_last
         && !cpu_wr_ctrl && !cpu_rd_data && !cpu_wr_data) |=> (irq_flag && dreq_flag));

endmodule

bind sbuf_irq_flags sbuf_irq_flags_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_tx       (mode_tx),
    .fmt_sync      (fmt_sync),
    .ev_start      (ev_start),
    .ev_byte_end   (ev_byte_end),
    .ev_tx_load    (ev_tx_load),
    .ev_rx_store   (ev_rx_store),
    .cpu_wr_ctrl   (cpu_wr_ctrl),
    .cpu_wdata_irq (cpu_wdata_irq),
    .cpu_rd_data   (cpu_rd_data),
    .cpu_wr_data   (cpu_wr_data),
    .dma_rd_data   (dma_rd_data),
    .dma_wr_data   (dma_wr_data),
    .dma_last      (dma_last),
    .irq_flag      (irq_flag),
    .dreq_flag     (dreq_flag),
    .tx_empty      (tx_empty),
    .rx_full       (rx_full)
);

// File: tb/sbuf_irq_flags_bench.sv
module sbuf_irq_flags_bench;

    // Stimulus bit positions.
    localparam logic [16:0] S_TX  = 17'h10000;
    localparam logic [16:0] S_SYN = 17'h08000;
    localparam logic [16:0] S_SLV = 17'h04000;
    localparam logic [16:0] S_STA = 17'h02000;
    localparam logic [16:0] S_STO = 17'h01000;
    localparam logic [16:0] S_BYE = 17'h00800;
    localparam logic [16:0] S_TXL = 17'h00400;
    localparam logic [16:0] S_RXS = 17'h00200;
    localparam logic [16:0] S_MAT = 17'h00100;
    localparam logic [16:0] S_RDC = 17'h00080;
    localparam logic [16:0] S_WRC = 17'h00040;
    localparam logic [16:0] S_W1  = 17'h00020;
    localparam logic [16:0] S_CRD = 17'h00010;
    localparam logic [16:0] S_CWR = 17'h00008;
    localparam logic [16:0] S_DRD = 17'h00004;
    localparam logic [16:0] S_DWR = 17'h00002;
    localparam logic [16:0] S_LST = 17'h00001;

    // Entry: {requirement tag, stimulus, expected {irq, dreq, tx_empty, rx_full}}.
    localparam int NV = 37;
    localparam logic [24:0] VEC [NV] = '{
        {4'd5,  S_RXS,                4'b1101},  // R5 receive store
        {4'd6,  S_WRC,                4'b1101},  // R6 write 0 without read
        {4'd6,  S_RDC,                4'b1101},  // R6 read as 1 arms
        {4'd6,  S_WRC | S_W1,         4'b1101},  // R6 write 1 ignored
        {4'd6,  S_WRC,                4'b1101},  // R6 latch consumed
        {4'd6,  S_RDC,                4'b1101},  // R6
        {4'd6,  S_WRC,                4'b0101},  // R6 clear, dreq kept
        {4'd11, S_CRD,                4'b0000},  // R11 CPU data read
        {4'd3,  S_TX | S_STA,         4'b1110},  // R3 start in transmit
        {4'd8,  S_TX | S_DWR,         4'b0000},  // R8 DMA write
        {4'd4,  S_TX | S_TXL,         4'b1110},  // R4 transmit load
        {4'd9,  S_TX | S_DWR | S_LST, 4'b1100},  // R9 last DMA write
        {4'd6,  S_RDC,                4'b1100},  // R6
        {4'd6,  S_WRC,                4'b0100},  // R6
        {4'd11, S_CWR,                4'b0000},  // R11 CPU data write
        {4'd4,  S_TXL,                4'b0000},  // R4 load ignored in receive
        {4'd2,  S_SYN | S_BYE,        4'b1000},  // R2 byte end
        {4'd6,  S_RDC,                4'b1000},  // R6
        {4'd6,  S_WRC,                4'b0000},  // R6
        {4'd2,  S_SYN | S_STA,        4'b1000},  // R2 start in sync format
        {4'd7,  S_RDC,                4'b1000},  // R7
        {4'd7,  S_WRC | S_SYN | S_BYE,4'b1000},  // R7 set beats clear
        {4'd6,  S_RDC,                4'b1000},  // R6
        {4'd6,  S_WRC,                4'b0000},  // R6
        {4'd10, S_SLV | S_MAT | S_RXS,4'b1001},  // R10 match cycle held
        {4'd11, S_CRD,                4'b1000},  // R11
        {4'd10, S_SLV | S_RXS,        4'b1001},  // R10 still held
        {4'd11, S_CRD,                4'b1000},  // R11
        {4'd10, S_STO,                4'b1000},  // R10 stop ends hold
        {4'd10, S_RXS,                4'b1101},  // R10 request again
        {4'd8,  S_DRD,                4'b0000},  // R8 DMA read
        {4'd5,  S_RXS,                4'b1101},  // R5
        {4'd9,  S_DRD | S_LST,        4'b1100},  // R9 last DMA read
        {4'd8,  S_DRD,                4'b0000},  // R8
        {4'd10, S_SLV | S_MAT,        4'b0000},  // R10 hold begins
        {4'd10, S_STA,                4'b0000},  // R10 start ends hold
        {4'd10, S_RXS,                4'b1101}   // R10 request again
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [16:0] stim = '0;
    logic irq_flag, dreq_flag, tx_empty, rx_full;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sbuf_irq_flags u_sbuf_irq_flags (
        .clk           (clk),
        .rst           (rst),
        .mode_tx       (stim[16]),
        .fmt_sync      (stim[15]),
        .slave_sel     (stim[14]),
        .ev_start      (stim[13]),
        .ev_stop       (stim[12]),
        .ev_byte_end   (stim[11]),
        .ev_tx_load    (stim[10]),
        .ev_rx_store   (stim[9]),
        .ev_addr_match (stim[8]),
        .cpu_rd_ctrl   (stim[7]),
        .cpu_wr_ctrl   (stim[6]),
        .cpu_wdata_irq (stim[5]),
        .cpu_rd_data   (stim[4]),
        .cpu_wr_data   (stim[3]),
        .dma_rd_data   (stim[2]),
        .dma_wr_data   (stim[1]),
        .dma_last      (stim[0]),
        .irq_flag      (irq_flag),
        .dreq_flag     (dreq_flag),
        .tx_empty      (tx_empty),
        .rx_full       (rx_full)
    );

    task automatic check(input int req, input logic [3:0] exp, input int idx);
        logic [3:0] act;
        act = {irq_flag, dreq_flag, tx_empty, rx_full};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d step %0d: flags %b expected %b", req, idx, act, exp);
        end
    endtask

    // Apply one cycle of stimulus at a falling edge, sample at the next one.
    task automatic step(input logic [16:0] s, input int req, input logic [3:0] exp, input int idx);
        stim = s;
        @(posedge clk);
        @(negedge clk);
        stim = '0;
        check(req, exp, idx);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(1, 4'b0000, 0);  // R1 reset state

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][20:4], int'(VEC[i][24:21]), VEC[i][3:0], i + 1);
        end

        // R1: reset in mid-run clears flags and the read-as-1 latch.
        step(S_RXS, 5, 4'b1101, 100);
        step(S_RDC, 6, 4'b1101, 101);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(1, 4'b0000, 102);
        step(S_RXS, 5, 4'b1101, 103);
        step(S_WRC, 1, 4'b1101, 104);  // R1 latch did not survive reset

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule